// File: doc/BRIEF.md
# Parallel NOR Flash Bus Front End

This block is a clock-synchronous model of the host-facing side of a parallel NOR flash that can run with either a 16-bit or an 8-bit data bus. Each clock it decodes the chip-select, output-enable, write-enable and reset inputs into one bus operation: read, write, standby, output disable or reset. Read data comes back one cycle later on a data bus. Each of the 16 lanes of that bus has its own registered enable. When an enable is low, that lane is taken as high impedance.

A small word-organised memory stands in for the flash array. In 8-bit mode the top data lane does not carry data. It is an extra, least-significant address input that picks the upper or lower half of the addressed word. A single flag switches the read path from the array to identification data. That data gives a manufacturer code, a device code that depends on the boot-block orientation parameter, and the protection state of the addressed sector, taken from a per-sector input vector. Program and erase timing are outside this block; an accepted write simply updates the memory.

Top module: `nor_bus_frontend`

## Requirements
- R1: With `byte_n` high, a read cycle (`ce_n`=0, `oe_n`=0, `we_n`=1, `rst_n`=1) gives, on the next cycle, `dq_oe`=16'hFFFF and `dq_out` equal to the word stored at `addr`.
- R2: With `byte_n` low, a read gives `dq_oe`=16'h00FF, so lanes 8 to 15 are undriven. `dq_in[15]` acts as the extra low address bit: 0 returns bits 7:0 of the word on lanes 7:0, and 1 returns bits 15:8 on lanes 7:0. `dq_out[15:8]` is zero.
- R3: A write cycle (`ce_n`=0, `we_n`=0, `oe_n`=1, `rst_n`=1) in array mode stores a word as follows. With `byte_n` high it stores all of `dq_in` at `addr`. With `byte_n` low it stores `dq_in[7:0]` into the half of the word chosen by `dq_in[15]` and leaves the other half unchanged. The next cycle has `dq_oe`=0.
- R4: Any cycle that is not a read has `dq_oe`=0 on the next cycle. This covers `ce_n` high (standby), `oe_n` high (output disable), and both `oe_n` and `we_n` low. A cycle with `ce_n` high and `we_n` low does not change the memory.
- R5: While `rst_n` is low, `dq_oe` is 0 from the next cycle on, and read and write cycles have no effect.
- R6: Identification mode turns on one cycle after `id_mode` is seen going from low to high, and turns off one cycle after `id_mode` is low. Reset turns it off. After reset, an `id_mode` that is still held high has no effect until it has been low once.
- R7: In identification mode, a read with `addr[6]`, `addr[1]` and `addr[0]` all zero returns 16'h0001, or 8'h01 in byte mode.
- R8: In identification mode, a read with `addr[6]`=0, `addr[1]`=0 and `addr[0]`=1 returns 16'h22EA when `TOP_BOOT`=1 and 16'h226B otherwise. In byte mode it returns only the low byte, whatever `dq_in[15]` is.
- R9: In identification mode, a read with `addr[6]`=0, `addr[1]`=1 and `addr[0]`=0 returns 1 if `sect_prot[s]` is set and 0 if it is clear. The sector `s` is the top `SECT_BITS` bits of `addr`.
- R10: In identification mode, the other address codes (`addr[6]`=1, or `addr[1:0]`=3) read as zero, and write cycles do not change the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Reset, active low, sampled on the clock |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| byte_n | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| id_mode | input | 1 | Identification-mode request flag |
| addr | input | ADDR_W | Word address |
| dq_in | input | 16 | Incoming data; bit 15 is the extra low address bit in 8-bit mode |
| sect_prot | input | 2**SECT_BITS | Protection bit for each sector |
| dq_out | output | 16 | Registered read data |
| dq_oe | output | 16 | Registered drive enable for each lane |

## Verification
The case hardest to reach from the ports is the interaction between reset and identification mode. The identification flag stays high across a reset pulse. The stimulus then has to show three things: an array read right after reset, no effect from the held flag, and identification data again only after the flag has dropped and risen. The bench checks this by writing a known word at the identification address before the reset, so the array read and the manufacturer code can be told apart. The other hard case is a byte-mode write where lane 15 picks the upper half. A word write, a half-word overwrite and then both word and byte read-backs show the half that must not change.

// File: rtl/nor_bus_frontend.sv
module nor_bus_frontend #(
  parameter int          ADDR_W    = 9,
  parameter int          SECT_BITS = 2,
  parameter bit          TOP_BOOT  = 1'b1,
  parameter logic [7:0]  MFR_CODE  = 8'h01,
  parameter logic [15:0] DEV_TOP   = 16'h22EA,
  parameter logic [15:0] DEV_BOT   = 16'h226B
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ce_n,
  input  logic                      oe_n,
  input  logic                      we_n,
  input  logic                      byte_n,
  input  logic                      id_mode,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [15:0]               dq_in,
  input  logic [(1<<SECT_BITS)-1:0] sect_prot,
  output logic [15:0]               dq_out,
  output logic [15:0]               dq_oe
);
  localparam int          DEPTH  = 1 << ADDR_W;
  localparam logic [15:0] DEV_ID = TOP_BOOT ? DEV_TOP : DEV_BOT;

  logic [15:0] mem [DEPTH];
  logic        id_act, id_prev;
  logic [15:0] id_word, rd_word, rd_data;
  logic [SECT_BITS-1:0] sect;

  wire op_rd = rst_n & ~ce_n & ~oe_n & we_n;
  wire op_wr = rst_n & ~ce_n & ~we_n & oe_n;
  wire am1   = dq_in[15];

  assign sect = addr[ADDR_W-1 -: SECT_BITS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      id_act  <= 1'b0;
      id_prev <= 1'b1;
    end else begin
      id_act  <= id_mode & (id_act | ~id_prev);
      id_prev <= id_mode;
    end
  end

  always_ff @(posedge clk) begin
    if (op_wr && !id_act) begin
      if (byte_n)   mem[addr]       <= dq_in;
      else if (am1) mem[addr][15:8] <= dq_in[7:0];
      else          mem[addr][7:0]  <= dq_in[7:0];
    end
  end

  always_comb begin
    case ({addr[6], addr[1], addr[0]})
      3'b000:  id_word = {8'h00, MFR_CODE};
      3'b001:  id_word = DEV_ID;
      3'b010:  id_word = {15'h0000, sect_prot[sect]};
      default: id_word = 16'h0000;
    endcase
  end

  assign rd_word = id_act ? id_word : mem[addr];
  assign rd_data = byte_n ? rd_word
                 : {8'h00, (am1 && !id_act) ? rd_word[15:8] : rd_word[7:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dq_oe  <= 16'h0000;
      dq_out <= 16'h0000;
    end else if (op_rd) begin
      dq_oe  <= byte_n ? 16'hFFFF : 16'h00FF;
      dq_out <= rd_data;
    end else begin
      dq_oe  <= 16'h0000;
      dq_out <= 16'h0000;
    end
  end
endmodule

// File: rtl/nor_bus_frontend_chk.sv
module nor_bus_frontend_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ce_n,
  input logic        oe_n,
  input logic        we_n,
  input logic        byte_n,
  input logic [15:0] dq_out,
  input logic [15:0] dq_oe
);
  logic rst_q = 1'b1;
  always @(posedge clk) rst_q <= rst_n;

  wire rd = ~ce_n & ~oe_n & we_n;

  p_word_lanes_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && byte_n) |=> dq_oe == 16'hFFFF);

  p_byte_lanes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !byte_n) |=> dq_oe == 16'h00FF);

  p_byte_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !byte_n) |=> dq_out[15:8] == 8'h00);

  p_idle_hiz_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> dq_oe == 16'h0000);

  p_reset_hiz_r5: assert property (@(posedge clk)
    !rst_q |-> dq_oe == 16'h0000);
endmodule

bind nor_bus_frontend nor_bus_frontend_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .byte_n(byte_n), .dq_out(dq_out), .dq_oe(dq_oe)
);

// File: tb/nor_bus_frontend_tb.sv
module nor_bus_frontend_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0, ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic        byte_n = 1'b1, id_mode = 1'b0;
  logic [8:0]  addr = '0;
  logic [15:0] dq_in = '0;
  logic [3:0]  sect_prot = 4'b0100;
  logic [15:0] dq_out, dq_oe;

  nor_bus_frontend u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .byte_n(byte_n), .id_mode(id_mode), .addr(addr), .dq_in(dq_in),
    .sect_prot(sect_prot), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  typedef struct {
    int          due;
    logic [15:0] oe;
    logic [15:0] data;
    string       req;
  } exp_t;

  exp_t q[$];
  int   cyc = 0, checks = 0, errors = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic cycle(input logic r, c, o, w, b, input logic [8:0] a,
                       input logic [15:0] d, input logic [15:0] eo,
                       input logic [15:0] ed, input string req);
    exp_t e;
    @(posedge clk); #2;
    rst_n = r; ce_n = c; oe_n = o; we_n = w; byte_n = b; addr = a; dq_in = d;
    e.due = cyc + 1; e.oe = eo; e.data = ed; e.req = req;
    q.push_back(e);
  endtask

  task automatic idle(input string req);
    cycle(1, 1, 1, 1, 1, '0, '0, 16'h0, 16'h0, req);
  endtask
  task automatic wr_w(input logic [8:0] a, input logic [15:0] d);
    cycle(1, 0, 1, 0, 1, a, d, 16'h0, 16'h0, "R3");
  endtask
  task automatic wr_b(input logic [8:0] a, input logic hi, input logic [7:0] d);
    cycle(1, 0, 1, 0, 0, a, {hi, 7'h00, d}, 16'h0, 16'h0, "R3");
  endtask
  task automatic rd_w(input logic [8:0] a, input logic [15:0] x, input string req);
    cycle(1, 0, 0, 1, 1, a, '0, 16'hFFFF, x, req);
  endtask
  task automatic rd_b(input logic [8:0] a, input logic hi, input logic [7:0] x,
                      input string req);
    cycle(1, 0, 0, 1, 0, a, {hi, 15'h0}, 16'h00FF, {8'h00, x}, req);
  endtask
  task automatic set_id(input logic v);
    @(posedge clk); #1; id_mode = v;
    idle("R6");
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (q.size() > 0 && q[0].due <= cyc) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (dq_oe !== e.oe || (dq_out & e.oe) !== e.data) begin
          errors++;
          $display("FAIL %s: oe=%h data=%h expected oe=%h data=%h",
                   e.req, dq_oe, dq_out & dq_oe, e.oe, e.data);
        end
      end
    end
  end

  initial begin : watchdog
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    // R5: reset state, read attempt during reset
    cycle(0, 0, 0, 1, 1, 9'h005, '0, 16'h0, 16'h0, "R5");
    cycle(0, 1, 1, 1, 1, '0, '0, 16'h0, 16'h0, "R5");
    // R3/R1: word writes and reads
    wr_w(9'h000, 16'h0BEE);
    wr_w(9'h005, 16'h1111);
    wr_w(9'h010, 16'hA5C3);
    rd_w(9'h005, 16'h1111, "R1");
    rd_w(9'h000, 16'h0BEE, "R1");
    // R3/R2: byte write to upper half, byte and word read-back
    wr_b(9'h010, 1'b1, 8'h7E);
    rd_w(9'h010, 16'h7EC3, "R3");
    rd_b(9'h010, 1'b0, 8'hC3, "R2");
    rd_b(9'h010, 1'b1, 8'h7E, "R2");
    wr_b(9'h010, 1'b0, 8'h19);
    rd_w(9'h010, 16'h7E19, "R3");
    // R4: non-read cycles
    cycle(1, 1, 0, 1, 1, 9'h005, '0, 16'h0, 16'h0, "R4");
    cycle(1, 0, 1, 1, 1, 9'h005, '0, 16'h0, 16'h0, "R4");
    cycle(1, 0, 0, 0, 1, 9'h005, 16'h2222, 16'h0, 16'h0, "R4");
    cycle(1, 1, 1, 0, 1, 9'h005, 16'h9999, 16'h0, 16'h0, "R4");
    rd_w(9'h005, 16'h1111, "R4");
    // R5: write during reset ignored
    cycle(0, 0, 1, 0, 1, 9'h005, 16'hDEAD, 16'h0, 16'h0, "R5");
    rd_w(9'h005, 16'h1111, "R5");
    // R6..R10: identification mode
    set_id(1'b1);
    rd_w(9'h000, 16'h0001, "R7");
    rd_b(9'h000, 1'b0, 8'h01, "R7");
    rd_w(9'h001, 16'h22EA, "R8");
    rd_b(9'h001, 1'b1, 8'hEA, "R8");
    rd_w(9'h102, 16'h0001, "R9");
    rd_w(9'h002, 16'h0000, "R9");
    rd_w(9'h182, 16'h0000, "R9");
    rd_w(9'h040, 16'h0000, "R10");
    rd_w(9'h003, 16'h0000, "R10");
    wr_w(9'h005, 16'h4444);
    set_id(1'b0);
    rd_w(9'h005, 16'h1111, "R10");
    rd_w(9'h000, 16'h0BEE, "R6");
    // R6: reset clears identification mode; held flag needs a new rise
    set_id(1'b1);
    rd_w(9'h000, 16'h0001, "R6");
    cycle(0, 1, 1, 1, 1, '0, '0, 16'h0, 16'h0, "R5");
    rd_w(9'h000, 16'h0BEE, "R6");
    rd_w(9'h000, 16'h0BEE, "R6");
    set_id(1'b0);
    set_id(1'b1);
    rd_w(9'h000, 16'h0001, "R6");
    idle("R4");
    idle("R4");
    wait (q.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule